// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block holds up to eight completed address translations so that repeated accesses to the same page skip the page-table walk. Each entry is tagged by an address-space identifier and the page number of the input address, which is the input address with its low granule bits removed. A lookup presents an identifier, an input address and a read/write flag. One cycle later the block returns either a hit, with the output address and a permission verdict, or a miss. On a miss, the surrounding logic walks the tables and writes the result back through the insert port. When the cache is already full and the new key is not present, every entry is dropped before the new one is written.

A separate maintenance port removes stale translations. It offers four operations: drop everything, drop all entries of one identifier, drop the one entry matching an identifier and page, and drop by page for any identifier. The last of these empties the whole cache. A maintenance request takes precedence over a lookup and an insert presented in the same cycle; both of those are then discarded.

The control path is a two-state machine. Reset enters `ST_CLEAR`, which wipes every valid bit and ignores all requests for one cycle. The machine then moves unconditionally to `ST_RUN`, where it stays until the next reset and serves lookups, inserts and maintenance.

Top module: `xlat_cache`

## Requirements
- R1: After reset every lookup misses. An accepted lookup yields `rsp_valid`=1 on the cycle after it is presented.
- R2: An entry matches only when both the identifier and the page number (the address bits above GRAN) are equal. Offsets within a page do not affect matching, and at most one entry matches a lookup.
- R3: On a hit, `rsp_addr` is the cached output page number concatenated with the low GRAN bits of the lookup address.
- R4: A write lookup (`lk_write`=1) that hits an entry inserted with `ins_wr_ok`=0 returns `rsp_fault`=1 together with `rsp_hit`=1. A read hit, a write hit on a writable entry, and any miss all give `rsp_fault`=0.
- R5: `rsp_report` equals `rsp_fault` when `lk_record`=1 and is 0 when `lk_record`=0.
- R6: Inserting a key that is already cached overwrites that entry and leaves all others intact. Inserting a new key into a full cache invalidates all eight entries and then stores only the new one.
- R7: `inv_op`=0 (all) and `inv_op`=3 (page, any identifier) both invalidate every entry.
- R8: `inv_op`=1 invalidates every entry whose identifier equals `inv_asid` and keeps all the others.
- R9: `inv_op`=2 invalidates only the entry matching both `inv_asid` and the page of `inv_addr`.
- R10: When `inv_valid`=1, a lookup in the same cycle produces no response (`rsp_valid`=0) and an insert in the same cycle is discarded.
- R11: The first cycle after reset release is `ST_CLEAR`. A lookup presented in that cycle gets no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_asid | input | ASID_W | Lookup address-space identifier |
| lk_addr | input | ADDR_W | Lookup input address |
| lk_write | input | 1 | Lookup is a write |
| lk_record | input | 1 | Report permission faults for this lookup |
| ins_valid | input | 1 | Insert request |
| ins_asid | input | ASID_W | Insert identifier |
| ins_addr | input | ADDR_W | Insert input address (offset ignored) |
| ins_page | input | OUT_W-GRAN | Output page number to store |
| ins_wr_ok | input | 1 | Stored page allows writes |
| inv_valid | input | 1 | Maintenance request |
| inv_op | input | 2 | 0 all, 1 by identifier, 2 identifier+page, 3 page any identifier |
| inv_asid | input | ASID_W | Maintenance identifier |
| inv_addr | input | ADDR_W | Maintenance address |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_addr | output | OUT_W | Translated address (0 on miss) |
| rsp_fault | output | 1 | Permission fault on a write hit |
| rsp_report | output | 1 | Fault to be reported |

## Verification
A corrupted valid bit or tag shows up one cycle after the next lookup of the affected key. It appears as a miss where a hit was due, or as a hit (possibly with a stale output page) after an invalidation. The sweeps therefore probe every cached key, with a read and with a write, after each fill, overwrite, full-cache flush and maintenance operation. A wrong write-permission bit appears as a wrong `rsp_fault` on the very next write probe of that page.

// File: rtl/xlat_cache_pkg.sv
package xlat_cache_pkg;
    typedef enum logic [1:0] {
        INV_ALL       = 2'd0,
        INV_ASID      = 2'd1,
        INV_ASID_PAGE = 2'd2,
        INV_PAGE_ANY  = 2'd3
    } inv_op_e;

    typedef enum logic {
        ST_CLEAR = 1'b0,
        ST_RUN   = 1'b1
    } cache_state_e;
endpackage

// File: rtl/xlat_tag_match.sv
module xlat_tag_match #(
    parameter int DEPTH  = 8,
    parameter int ASID_W = 8,
    parameter int VPN_W  = 20
) (
    input  logic [DEPTH-1:0]             ent_v,
    input  logic [DEPTH-1:0][ASID_W-1:0] ent_asid,
    input  logic [DEPTH-1:0][VPN_W-1:0]  ent_vpn,
    input  logic [ASID_W-1:0]            key_asid,
    input  logic [VPN_W-1:0]             key_vpn,
    output logic [DEPTH-1:0]             asid_hit,
    output logic [DEPTH-1:0]             full_hit
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign asid_hit[g] = ent_v[g] && (ent_asid[g] == key_asid);
        assign full_hit[g] = asid_hit[g] && (ent_vpn[g] == key_vpn);
    end
endmodule

// File: rtl/xlat_slot_alloc.sv
module xlat_slot_alloc #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input  logic [DEPTH-1:0] ent_v,
    input  logic [DEPTH-1:0] same_key,
    output logic [IDX_W-1:0] slot,
    output logic             flush_all
);
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] same_idx;
    logic             found;

    always_comb begin
        free_idx = '0;
        found    = 1'b0;
        same_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!ent_v[i] && !found) begin
                free_idx = IDX_W'(i);
                found    = 1'b1;
            end
            if (same_key[i]) same_idx = IDX_W'(i);
        end
    end

    always_comb begin
        flush_all = 1'b0;
        if (|same_key)      slot = same_idx;
        else if (found)     slot = free_idx;
        else begin
            slot      = '0;
            flush_all = 1'b1;
        end
    end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_cache_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ASID_W = 8,
    parameter int ADDR_W = 32,
    parameter int OUT_W  = 32,
    parameter int GRAN   = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lk_valid,
    input  logic [ASID_W-1:0]    lk_asid,
    input  logic [ADDR_W-1:0]    lk_addr,
    input  logic                 lk_write,
    input  logic                 lk_record,
    input  logic                 ins_valid,
    input  logic [ASID_W-1:0]    ins_asid,
    input  logic [ADDR_W-1:0]    ins_addr,
    input  logic [OUT_W-GRAN-1:0] ins_page,
    input  logic                 ins_wr_ok,
    input  logic                 inv_valid,
    input  logic [1:0]           inv_op,
    input  logic [ASID_W-1:0]    inv_asid,
    input  logic [ADDR_W-1:0]    inv_addr,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic [OUT_W-1:0]     rsp_addr,
    output logic                 rsp_fault,
    output logic                 rsp_report
);
    localparam int VPN_W = ADDR_W - GRAN;
    localparam int PPN_W = OUT_W - GRAN;
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    cache_state_e state, state_nx;

    logic [DEPTH-1:0]             ent_v;
    logic [DEPTH-1:0][ASID_W-1:0] ent_asid;
    logic [DEPTH-1:0][VPN_W-1:0]  ent_vpn;
    logic [DEPTH-1:0][PPN_W-1:0]  ent_ppn;
    logic [DEPTH-1:0]             ent_wr;

    logic [DEPTH-1:0] lk_asid_hit, lk_hit;
    logic [DEPTH-1:0] ins_asid_hit, ins_hit;
    logic [DEPTH-1:0] inv_asid_hit, inv_hit;
    logic [DEPTH-1:0] kill;
    logic [IDX_W-1:0] ins_slot;
    logic             ins_flush;
    logic [PPN_W-1:0] hit_ppn;
    logic             hit_wr;
    logic             running;

    assign running = (state == ST_RUN);

    xlat_tag_match #(.DEPTH(DEPTH), .ASID_W(ASID_W), .VPN_W(VPN_W)) u_lk_match (
        .ent_v(ent_v), .ent_asid(ent_asid), .ent_vpn(ent_vpn),
        .key_asid(lk_asid), .key_vpn(lk_addr[ADDR_W-1:GRAN]),
        .asid_hit(lk_asid_hit), .full_hit(lk_hit)
    );

    xlat_tag_match #(.DEPTH(DEPTH), .ASID_W(ASID_W), .VPN_W(VPN_W)) u_ins_match (
        .ent_v(ent_v), .ent_asid(ent_asid), .ent_vpn(ent_vpn),
        .key_asid(ins_asid), .key_vpn(ins_addr[ADDR_W-1:GRAN]),
        .asid_hit(ins_asid_hit), .full_hit(ins_hit)
    );

    xlat_tag_match #(.DEPTH(DEPTH), .ASID_W(ASID_W), .VPN_W(VPN_W)) u_inv_match (
        .ent_v(ent_v), .ent_asid(ent_asid), .ent_vpn(ent_vpn),
        .key_asid(inv_asid), .key_vpn(inv_addr[ADDR_W-1:GRAN]),
        .asid_hit(inv_asid_hit), .full_hit(inv_hit)
    );

    xlat_slot_alloc #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_alloc (
        .ent_v(ent_v), .same_key(ins_hit),
        .slot(ins_slot), .flush_all(ins_flush)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_CLEAR;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_CLEAR: state_nx = ST_RUN;
            ST_RUN:   state_nx = ST_RUN;
            default:  state_nx = ST_CLEAR;
        endcase
    end

    // Entries to drop on a maintenance request
    always_comb begin
        unique case (inv_op_e'(inv_op))
            INV_ALL, INV_PAGE_ANY: kill = '1;
            INV_ASID:              kill = inv_asid_hit;
            INV_ASID_PAGE:         kill = inv_hit;
            default:               kill = '1;
        endcase
    end

    // Read data of the hitting entry (at most one)
    always_comb begin
        hit_ppn = '0;
        hit_wr  = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (lk_hit[i]) begin
                hit_ppn = hit_ppn | ent_ppn[i];
                hit_wr  = hit_wr  | ent_wr[i];
            end
        end
    end

    // Entry storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_v <= '0;
        end else if (!running) begin
            ent_v <= '0;
        end else if (inv_valid) begin
            ent_v <= ent_v & ~kill;
        end else if (ins_valid) begin
            ent_v <= (ins_flush ? {DEPTH{1'b0}} : ent_v)
                   | ({{(DEPTH-1){1'b0}}, 1'b1} << ins_slot);
        end
    end

    always_ff @(posedge clk) begin
        if (running && !inv_valid && ins_valid) begin
            ent_asid[ins_slot] <= ins_asid;
            ent_vpn[ins_slot]  <= ins_addr[ADDR_W-1:GRAN];
            ent_ppn[ins_slot]  <= ins_page;
            ent_wr[ins_slot]   <= ins_wr_ok;
        end
    end

    // Output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_addr   <= '0;
            rsp_fault  <= 1'b0;
            rsp_report <= 1'b0;
        end else begin
            rsp_valid  <= lk_valid && running && !inv_valid;
            rsp_hit    <= |lk_hit;
            rsp_addr   <= (|lk_hit) ? {hit_ppn, lk_addr[GRAN-1:0]} : '0;
            rsp_fault  <= (|lk_hit) && lk_write && !hit_wr;
            rsp_report <= (|lk_hit) && lk_write && !hit_wr && lk_record;
        end
    end

    // Assertions
    p_rsp_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && running && !inv_valid) |=> rsp_valid);
    p_single_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hit));
    p_fault_on_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_hit);
    p_report_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_report |-> rsp_fault);
    p_full_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !inv_valid && ins_valid && (&ent_v) && !(|ins_hit))
        |=> ($countones(ent_v) == 1));
    p_inv_wipe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && (inv_op == 2'd0 || inv_op == 2'd3)) |=> (ent_v == '0));
    p_inv_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |=> !rsp_valid);
    p_clear_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLEAR) |=> !rsp_valid);
endmodule

// File: tb/sim_xlat_cache.sv
module sim_xlat_cache;
    localparam int AS = 8;
    localparam int AW = 32;
    localparam int OW = 32;
    localparam int GR = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_valid = 0, lk_write = 0, lk_record = 0;
    logic [AS-1:0] lk_asid = '0;
    logic [AW-1:0] lk_addr = '0;
    logic ins_valid = 0, ins_wr_ok = 0;
    logic [AS-1:0] ins_asid = '0;
    logic [AW-1:0] ins_addr = '0;
    logic [OW-GR-1:0] ins_page = '0;
    logic inv_valid = 0;
    logic [1:0] inv_op = '0;
    logic [AS-1:0] inv_asid = '0;
    logic [AW-1:0] inv_addr = '0;
    logic rsp_valid, rsp_hit, rsp_fault, rsp_report;
    logic [OW-1:0] rsp_addr;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [AS-1:0] kasid [10];
    logic [19:0]   kvpn  [10];
    logic [19:0]   kppn  [10];
    logic          kwr   [10];

    always #4 clk = ~clk;

    xlat_cache u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_asid(lk_asid), .lk_addr(lk_addr),
        .lk_write(lk_write), .lk_record(lk_record),
        .ins_valid(ins_valid), .ins_asid(ins_asid), .ins_addr(ins_addr),
        .ins_page(ins_page), .ins_wr_ok(ins_wr_ok),
        .inv_valid(inv_valid), .inv_op(inv_op), .inv_asid(inv_asid), .inv_addr(inv_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_addr(rsp_addr),
        .rsp_fault(rsp_fault), .rsp_report(rsp_report)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic lookup(input logic [AS-1:0] a, input logic [AW-1:0] addr, input logic w, input logic rec);
        @(negedge clk);
        lk_valid = 1; lk_asid = a; lk_addr = addr; lk_write = w; lk_record = rec;
        @(negedge clk);
        lk_valid = 0;
    endtask

    task automatic insert(input int k);
        @(negedge clk);
        ins_valid = 1; ins_asid = kasid[k]; ins_addr = {kvpn[k], 12'h000};
        ins_page = kppn[k]; ins_wr_ok = kwr[k];
        @(negedge clk);
        ins_valid = 0;
    endtask

    task automatic maint(input logic [1:0] op, input logic [AS-1:0] a, input logic [AW-1:0] addr);
        @(negedge clk);
        inv_valid = 1; inv_op = op; inv_asid = a; inv_addr = addr;
        @(negedge clk);
        inv_valid = 0;
    endtask

    // Probe key k with a read and a write; offset computed from the page number
    task automatic probe(input int k, input bit exp_hit, input string req);
        logic [11:0] off;
        off = 12'((kvpn[k] * 37 + 5) & 20'hFFF);
        lookup(kasid[k], {kvpn[k], off}, 1'b0, 1'b1);
        chk(req, "rd valid", 32'(rsp_valid), 32'd1);
        chk(req, "rd hit", 32'(rsp_hit), 32'(exp_hit));
        if (exp_hit) chk("R3", "addr", rsp_addr, {kppn[k], off});
        chk("R4", "rd fault", 32'(rsp_fault), 32'd0);
        lookup(kasid[k], {kvpn[k], off}, 1'b1, 1'b1);
        chk("R4", "wr fault", 32'(rsp_fault), 32'(exp_hit && !kwr[k]));
        chk("R5", "wr report", 32'(rsp_report), 32'(exp_hit && !kwr[k]));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            kasid[i] = i[0] ? 8'h05 : 8'h03;
            kvpn[i]  = 20'h00100 + 20'(i);
            kppn[i]  = 20'h80000 + 20'(i * 3);
            kwr[i]   = i[1];
        end
        kasid[8] = 8'h03; kvpn[8] = 20'h00200; kppn[8] = 20'h9ABCD; kwr[8] = 1'b1;
        kasid[9] = 8'h07; kvpn[9] = 20'h00300; kppn[9] = 20'h12345; kwr[9] = 1'b0;

        repeat (3) @(negedge clk);
        chk("R1", "reset rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R1", "reset rsp_hit", 32'(rsp_hit), 32'd0);
        // R11: lookup in the clear cycle gets no response
        rst_n = 1; lk_valid = 1; lk_asid = 8'h03; lk_addr = 32'h00100000;
        @(negedge clk);
        lk_valid = 0;
        chk("R11", "clear-cycle rsp_valid", 32'(rsp_valid), 32'd0);

        // R1: empty cache misses everything
        for (int i = 0; i < 8; i++) probe(i, 1'b0, "R1");

        // Fill and sweep (R2 R3 R4 R5)
        for (int i = 0; i < 8; i++) insert(i);
        for (int i = 0; i < 8; i++) probe(i, 1'b1, "R2");
        // R2: wrong identifier misses
        lookup(8'h09, {kvpn[0], 12'h010}, 1'b0, 1'b1);
        chk("R2", "foreign asid hit", 32'(rsp_hit), 32'd0);
        // R2: swapped identifiers between neighbours miss
        lookup(kasid[1], {kvpn[0], 12'h010}, 1'b0, 1'b1);
        chk("R2", "swapped asid hit", 32'(rsp_hit), 32'd0);
        // R5: fault without record flag is not reported
        lookup(kasid[0], {kvpn[0], 12'hABC}, 1'b1, 1'b0);
        chk("R5", "fault no record", 32'(rsp_fault), 32'd1);
        chk("R5", "report no record", 32'(rsp_report), 32'd0);

        // R6: overwrite existing key keeps the others
        kppn[0] = 20'h4F00D; kwr[0] = 1'b1;
        insert(0);
        for (int i = 0; i < 8; i++) probe(i, 1'b1, "R6");
        // R6: new key into a full cache flushes everything
        insert(8);
        for (int i = 0; i < 8; i++) probe(i, 1'b0, "R6");
        probe(8, 1'b1, "R6");

        // R8: refill then drop identifier 5
        maint(2'd0, 8'h00, 32'h0);
        for (int i = 0; i < 8; i++) insert(i);
        maint(2'd1, 8'h05, 32'h0);
        for (int i = 0; i < 8; i++) probe(i, (kasid[i] != 8'h05), "R8");

        // R9: drop one identifier+page entry
        maint(2'd2, kasid[2], {kvpn[2], 12'h777});
        for (int i = 0; i < 8; i++) probe(i, (kasid[i] != 8'h05) && (i != 2), "R9");

        // R7: page-any wipes all, including other pages
        maint(2'd3, 8'h00, {kvpn[0], 12'h000});
        for (int i = 0; i < 8; i++) probe(i, 1'b0, "R7");
        for (int i = 0; i < 4; i++) insert(i);
        maint(2'd0, 8'h00, 32'h0);
        for (int i = 0; i < 4; i++) probe(i, 1'b0, "R7");

        // R10: maintenance beats a same-cycle lookup and insert
        insert(0);
        @(negedge clk);
        inv_valid = 1; inv_op = 2'd1; inv_asid = 8'h44;
        lk_valid = 1; lk_asid = kasid[0]; lk_addr = {kvpn[0], 12'h001}; lk_write = 0;
        ins_valid = 1; ins_asid = kasid[9]; ins_addr = {kvpn[9], 12'h0};
        ins_page = kppn[9]; ins_wr_ok = kwr[9];
        @(negedge clk);
        inv_valid = 0; lk_valid = 0; ins_valid = 0;
        chk("R10", "rsp_valid under maintenance", 32'(rsp_valid), 32'd0);
        probe(9, 1'b0, "R10");
        probe(0, 1'b1, "R10");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule